// File: doc/BRIEF.md
# Special Register Access Unit

This unit services move-to and move-from special-register requests issued by a small 32-bit RISC pipeline. It forms each register address by OR-ing a base operand with a 16-bit immediate, splits that address into a 5-bit group (bits [15:11]) and an 11-bit index (bits [10:0]), and then either updates the selected register or returns its value on the same cycle. It holds the supervision/status register, the exception bookkeeping registers, a 64-bit multiply-accumulate register seen as two 32-bit halves, and the interrupt-controller enable and pending registers. It also answers two fixed identification registers.

Two side effects are produced for neighbouring logic. A status-register write that changes address-translation enables or the privilege bit raises a one-cycle TLB-flush strobe. A write to the next-PC register with a value different from the current PC starts a redirect handshake, run by a two-state machine: `ST_IDLE` moves to `ST_REDIRECT` on such a write (transition *take*), and `ST_REDIRECT` returns to `ST_IDLE` when the pipeline acknowledges (transition *done*). The TLB arrays, tick timer and pipeline redirect logic themselves live elsewhere.

Top module: `spr_access_unit`

## Requirements
- R1: The register address is `req_base | req_imm`; only addresses whose bits above bit 15 are all zero are recognised, with group = bits [15:11] and index = bits [10:0]; a write to any other address changes no register.
- R2: Group 0 index 128 reads as the core identifier (default 0) and group 0 index 129 as the core count (default 1); writes to either have no effect.
- R3: A write to the interrupt enable register (group 9 index 0) sets it to its old value OR the written data.
- R4: A write to the interrupt pending register (group 9 index 2) clears each bit that is 1 in the written data; a bit of `irq_i` that is 1 in a cycle sets that pending bit at the next edge and wins over a clear of the same bit in the same cycle.
- R5: The accumulator low half is group 5 index 1 (bits [31:0]) and the high half is group 5 index 2 (bits [63:32]); writing one half leaves the other unchanged.
- R6: A write to the status register (group 0 index 17) that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) makes `tlb_flush` 1 for exactly the following cycle; a write changing none of these leaves it 0.
- R7: A read of an unrecognised address, or any cycle without a read request, drives `rdata` with `req_rd_prev`.
- R8: A write to next-PC (group 0 index 16) in `ST_IDLE` whose data differs from `pc_i` moves to `ST_REDIRECT`: from the next cycle `redirect_req` is 1 with `redirect_pc` holding the data, and `dslot_clr` is 1 for that first cycle only; the request and target hold until the cycle after `redirect_ack`; a next-PC write equal to `pc_i`, or any next-PC write while in `ST_REDIRECT`, has no effect; reading next-PC returns `pc_i`.
- R9: Exception registers at group 0 indices 11, 32, 48 and 64 are plain 32-bit read/write storage.
- R10: After reset the accumulator, interrupt enable and interrupt pending registers read 0, the status register reads 1 (supervisor set), and `tlb_flush`, `redirect_req` and `dslot_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_base | input | DATA_W | Base operand of the address |
| req_imm | input | 16 | Immediate ORed into the address |
| req_wdata | input | DATA_W | Write data |
| req_rd_prev | input | DATA_W | Current value of the destination register |
| rdata | output | DATA_W | Read result, combinational |
| pc_i | input | DATA_W | Current program counter |
| redirect_ack | input | 1 | Pipeline accepted the redirect |
| redirect_req | output | 1 | Redirect pending |
| redirect_pc | output | DATA_W | Redirect target |
| dslot_clr | output | 1 | Clear the delay-slot flag (one cycle) |
| tlb_flush | output | 1 | Flush translation buffers (one cycle) |
| irq_i | input | NUM_IRQ | Interrupt lines setting pending bits |

## Verification
The hardest situation to reach is the collision on the pending register, where a software clear and an interrupt line target the same bit in one cycle while a neighbouring bit is cleared alone. The stimulus first fills the pending register through a one-cycle interrupt pulse, then issues the clear with one line held high in the same cycle, and reads the register back to see the mixed result. The redirect machine is driven into `ST_REDIRECT` and given a second next-PC write while the acknowledge is withheld, so that the held target can be seen to survive.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int ADDR_W = 16;
    localparam int GRP_W  = 5;
    localparam int IDX_W  = 11;

    // Status register bits that affect address translation or privilege
    localparam int SR_SUPV_BIT = 0;
    localparam int SR_DTE_BIT  = 5;
    localparam int SR_ITE_BIT  = 6;

    function automatic logic [ADDR_W-1:0] spr_key(input int grp, input int idx);
        return {GRP_W'(grp), IDX_W'(idx)};
    endfunction

    localparam logic [ADDR_W-1:0] KEY_EVBAR  = spr_key(0, 11);
    localparam logic [ADDR_W-1:0] KEY_NPC    = spr_key(0, 16);
    localparam logic [ADDR_W-1:0] KEY_SR     = spr_key(0, 17);
    localparam logic [ADDR_W-1:0] KEY_EPCR   = spr_key(0, 32);
    localparam logic [ADDR_W-1:0] KEY_EEAR   = spr_key(0, 48);
    localparam logic [ADDR_W-1:0] KEY_ESR    = spr_key(0, 64);
    localparam logic [ADDR_W-1:0] KEY_COREID = spr_key(0, 128);
    localparam logic [ADDR_W-1:0] KEY_NCORES = spr_key(0, 129);
    localparam logic [ADDR_W-1:0] KEY_MACLO  = spr_key(5, 1);
    localparam logic [ADDR_W-1:0] KEY_MACHI  = spr_key(5, 2);
    localparam logic [ADDR_W-1:0] KEY_PICEN  = spr_key(9, 0);
    localparam logic [ADDR_W-1:0] KEY_PICPND = spr_key(9, 2);

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SR,
        SEL_NPC,
        SEL_EPCR,
        SEL_EEAR,
        SEL_ESR,
        SEL_EVBAR,
        SEL_COREID,
        SEL_NCORES,
        SEL_MACLO,
        SEL_MACHI,
        SEL_PICEN,
        SEL_PICPND
    } spr_sel_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_REDIRECT
    } redir_state_e;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [ADDR_W-1:0] imm,
    output spr_sel_e          sel
);

    localparam int HI_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] addr;
    logic              in_range;

    assign addr     = base | DATA_W'(imm);
    assign in_range = (addr[DATA_W-1:ADDR_W] == HI_W'(0));

    always_comb begin
        sel = SEL_NONE;
        if (in_range) begin
            unique case (addr[ADDR_W-1:0])
                KEY_SR:     sel = SEL_SR;
                KEY_NPC:    sel = SEL_NPC;
                KEY_EPCR:   sel = SEL_EPCR;
                KEY_EEAR:   sel = SEL_EEAR;
                KEY_ESR:    sel = SEL_ESR;
                KEY_EVBAR:  sel = SEL_EVBAR;
                KEY_COREID: sel = SEL_COREID;
                KEY_NCORES: sel = SEL_NCORES;
                KEY_MACLO:  sel = SEL_MACLO;
                KEY_MACHI:  sel = SEL_MACHI;
                KEY_PICEN:  sel = SEL_PICEN;
                KEY_PICPND: sel = SEL_PICPND;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
    import spr_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] SR_RESET = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  spr_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pc_i,
    input  logic              redirect_ack,
    output logic [DATA_W-1:0] sr_q,
    output logic [DATA_W-1:0] epcr_q,
    output logic [DATA_W-1:0] eear_q,
    output logic [DATA_W-1:0] esr_q,
    output logic [DATA_W-1:0] evbar_q,
    output logic              tlb_flush,
    output logic              redirect_req,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              dslot_clr
);

    localparam logic [DATA_W-1:0] WATCH_MASK =
        (DATA_W'(1) << SR_SUPV_BIT) |
        (DATA_W'(1) << SR_DTE_BIT)  |
        (DATA_W'(1) << SR_ITE_BIT);

    redir_state_e state_q, state_d;
    logic         take;
    logic         flush_q;
    logic         dclr_q;
    logic [DATA_W-1:0] target_q;

    // Plain storage and status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= DATA_W'(SR_RESET);
            epcr_q  <= '0;
            eear_q  <= '0;
            esr_q   <= '0;
            evbar_q <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (wr_en) begin
                unique case (sel)
                    SEL_SR: begin
                        sr_q    <= wdata;
                        flush_q <= |((sr_q ^ wdata) & WATCH_MASK);
                    end
                    SEL_EPCR:  epcr_q  <= wdata;
                    SEL_EEAR:  eear_q  <= wdata;
                    SEL_ESR:   esr_q   <= wdata;
                    SEL_EVBAR: evbar_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Redirect machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
            dclr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dclr_q  <= take;
            if (take) begin
                target_q <= wdata;
            end
        end
    end

    // Redirect machine: transitions
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && (sel == SEL_NPC) && (wdata != pc_i)) begin
                    take    = 1'b1;
                    state_d = ST_REDIRECT;
                end
            end
            ST_REDIRECT: begin
                if (redirect_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Redirect machine: outputs
    always_comb begin
        redirect_req = 1'b0;
        unique case (state_q)
            ST_IDLE:     redirect_req = 1'b0;
            ST_REDIRECT: redirect_req = 1'b1;
            default:     redirect_req = 1'b0;
        endcase
    end

    assign redirect_pc = target_q;
    assign dslot_clr   = dclr_q;
    assign tlb_flush   = flush_q;

endmodule

// File: rtl/spr_mac_pic.sv
module spr_mac_pic
    import spr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  spr_sel_e            sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_IRQ-1:0]  irq_i,
    output logic [DATA_W-1:0]   mac_lo,
    output logic [DATA_W-1:0]   mac_hi,
    output logic [NUM_IRQ-1:0]  pic_en,
    output logic [NUM_IRQ-1:0]  pic_pnd
);

    localparam int MAC_W = 2 * DATA_W;

    logic [MAC_W-1:0]   acc_q;
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] pnd_q;
    logic [NUM_IRQ-1:0] pnd_d;
    logic [NUM_IRQ-1:0] clr_bits;

    assign clr_bits = (wr_en && sel == SEL_PICPND) ? wdata[NUM_IRQ-1:0] : '0;

    // Per-line pending update: a hardware set beats a software clear
    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_pnd
        always_comb begin
            if (irq_i[b]) begin
                pnd_d[b] = 1'b1;
            end else if (clr_bits[b]) begin
                pnd_d[b] = 1'b0;
            end else begin
                pnd_d[b] = pnd_q[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            en_q  <= '0;
            pnd_q <= '0;
        end else begin
            pnd_q <= pnd_d;
            if (wr_en) begin
                unique case (sel)
                    SEL_MACLO: acc_q[DATA_W-1:0]     <= wdata;
                    SEL_MACHI: acc_q[MAC_W-1:DATA_W] <= wdata;
                    SEL_PICEN: en_q                  <= en_q | wdata[NUM_IRQ-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign mac_lo  = acc_q[DATA_W-1:0];
    assign mac_hi  = acc_q[MAC_W-1:DATA_W];
    assign pic_en  = en_q;
    assign pic_pnd = pnd_q;

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          NUM_IRQ   = 32,
    parameter int          CORE_ID   = 0,
    parameter int          NUM_CORES = 1,
    parameter logic [31:0] SR_RESET  = 32'h0000_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [DATA_W-1:0]  req_base,
    input  logic [15:0]        req_imm,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  req_rd_prev,
    output logic [DATA_W-1:0]  rdata,
    input  logic [DATA_W-1:0]  pc_i,
    input  logic               redirect_ack,
    output logic               redirect_req,
    output logic [DATA_W-1:0]  redirect_pc,
    output logic               dslot_clr,
    output logic               tlb_flush,
    input  logic [NUM_IRQ-1:0] irq_i
);

    spr_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] sr_q, epcr_q, eear_q, esr_q, evbar_q;
    logic [DATA_W-1:0] mac_lo, mac_hi;
    logic [NUM_IRQ-1:0] pic_en, pic_pnd;

    assign wr_en = req_valid &&  req_we;
    assign rd_en = req_valid && !req_we;

    spr_decode #(.DATA_W(DATA_W)) u_dec (
        .base (req_base),
        .imm  (req_imm),
        .sel  (sel)
    );

    spr_sys_regs #(.DATA_W(DATA_W), .SR_RESET(SR_RESET)) u_sys (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .sel          (sel),
        .wdata        (req_wdata),
        .pc_i         (pc_i),
        .redirect_ack (redirect_ack),
        .sr_q         (sr_q),
        .epcr_q       (epcr_q),
        .eear_q       (eear_q),
        .esr_q        (esr_q),
        .evbar_q      (evbar_q),
        .tlb_flush    (tlb_flush),
        .redirect_req (redirect_req),
        .redirect_pc  (redirect_pc),
        .dslot_clr    (dslot_clr)
    );

    spr_mac_pic #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_mp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (req_wdata),
        .irq_i   (irq_i),
        .mac_lo  (mac_lo),
        .mac_hi  (mac_hi),
        .pic_en  (pic_en),
        .pic_pnd (pic_pnd)
    );

    // Read multiplexer: unrecognised or absent reads pass the old value
    always_comb begin
        rdata = req_rd_prev;
        if (rd_en) begin
            unique case (sel)
                SEL_SR:     rdata = sr_q;
                SEL_NPC:    rdata = pc_i;
                SEL_EPCR:   rdata = epcr_q;
                SEL_EEAR:   rdata = eear_q;
                SEL_ESR:    rdata = esr_q;
                SEL_EVBAR:  rdata = evbar_q;
                SEL_COREID: rdata = DATA_W'(CORE_ID);
                SEL_NCORES: rdata = DATA_W'(NUM_CORES);
                SEL_MACLO:  rdata = mac_lo;
                SEL_MACHI:  rdata = mac_hi;
                SEL_PICEN:  rdata = DATA_W'(pic_en);
                SEL_PICPND: rdata = DATA_W'(pic_pnd);
                default:    rdata = req_rd_prev;
            endcase
        end
    end

endmodule

// File: rtl/spr_access_unit_chk.sv
module spr_access_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int CORE_ID   = 0,
    parameter int NUM_CORES = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [DATA_W-1:0] req_base,
    input logic [15:0]       req_imm,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] req_rd_prev,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] pc_i,
    input logic              redirect_ack,
    input logic              redirect_req,
    input logic [DATA_W-1:0] redirect_pc,
    input logic              dslot_clr,
    input logic              tlb_flush
);

    logic [DATA_W-1:0] a_full;
    logic              a_ok;
    logic [15:0]       a_key;
    logic              is_rd;
    logic              is_wr;

    assign a_full = req_base | DATA_W'(req_imm);
    assign a_ok   = (a_full[DATA_W-1:16] == '0);
    assign a_key  = a_full[15:0];
    assign is_rd  = req_valid && !req_we;
    assign is_wr  = req_valid &&  req_we;

    // R2: identification reads are fixed
    assert_coreid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && a_ok && a_key == 16'd128) |-> rdata == DATA_W'(CORE_ID));
    assert_numcores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && a_ok && a_key == 16'd129) |-> rdata == DATA_W'(NUM_CORES));

    // R7: out-of-range address returns the old destination value
    assert_unknown_prev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !a_ok) |-> rdata == req_rd_prev);

    // R6: a flush pulse only follows a status write
    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(is_wr && a_ok && a_key == 16'd17));

    // R8: redirect holds until acknowledged
    assert_redirect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_req && !redirect_ack) |=> (redirect_req && $stable(redirect_pc)));
    assert_dslot_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dslot_clr |-> redirect_req);
    assert_redirect_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_req) |-> $past(is_wr && a_ok && a_key == 16'd16 && req_wdata != pc_i));

endmodule

bind spr_access_unit spr_access_unit_chk #(
    .DATA_W(DATA_W), .CORE_ID(CORE_ID), .NUM_CORES(NUM_CORES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_we       (req_we),
    .req_base     (req_base),
    .req_imm      (req_imm),
    .req_wdata    (req_wdata),
    .req_rd_prev  (req_rd_prev),
    .rdata        (rdata),
    .pc_i         (pc_i),
    .redirect_ack (redirect_ack),
    .redirect_req (redirect_req),
    .redirect_pc  (redirect_pc),
    .dslot_clr    (dslot_clr),
    .tlb_flush    (tlb_flush)
);

// File: tb/spr_access_unit_tb_top.sv
`timescale 1ns/1ps
module spr_access_unit_tb_top;

    localparam int W = 32;

    localparam logic [15:0] A_EVBAR  = 16'd11;
    localparam logic [15:0] A_NPC    = 16'd16;
    localparam logic [15:0] A_SR     = 16'd17;
    localparam logic [15:0] A_EPCR   = 16'd32;
    localparam logic [15:0] A_EEAR   = 16'd48;
    localparam logic [15:0] A_ESR    = 16'd64;
    localparam logic [15:0] A_COREID = 16'd128;
    localparam logic [15:0] A_NCORES = 16'd129;
    localparam logic [15:0] A_MACLO  = 16'h2801;
    localparam logic [15:0] A_MACHI  = 16'h2802;
    localparam logic [15:0] A_PICEN  = 16'h4800;
    localparam logic [15:0] A_PICPND = 16'h4802;

    typedef enum int { K_RDATA, K_FLUSH, K_REQ, K_RPC, K_DCLR } kind_e;
    typedef struct {
        kind_e       kind;
        string       req;
        logic [31:0] exp;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [W-1:0]  req_base = '0;
    logic [15:0]   req_imm = '0;
    logic [W-1:0]  req_wdata = '0;
    logic [W-1:0]  req_rd_prev = '0;
    logic [W-1:0]  rdata;
    logic [W-1:0]  pc_i = 32'h100;
    logic          redirect_ack = 1'b0;
    logic          redirect_req;
    logic [W-1:0]  redirect_pc;
    logic          dslot_clr;
    logic          tlb_flush;
    logic [31:0]   irq_i = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    item_t exp_q[$];

    always #10 clk = ~clk;

    spr_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .req_rd_prev(req_rd_prev), .rdata(rdata), .pc_i(pc_i),
        .redirect_ack(redirect_ack), .redirect_req(redirect_req),
        .redirect_pc(redirect_pc), .dslot_clr(dslot_clr),
        .tlb_flush(tlb_flush), .irq_i(irq_i)
    );

    task automatic expect_item(input kind_e k, input string r, input logic [31:0] e);
        item_t it;
        it.kind = k; it.req = r; it.exp = e;
        exp_q.push_back(it);
    endtask

    task automatic drive(input logic we, input logic [31:0] base, input logic [15:0] imm,
                         input logic [31:0] wd, input logic [31:0] prev);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_base = base; req_imm = imm;
        req_wdata = wd; req_rd_prev = prev;
    endtask

    task automatic wr(input logic [15:0] imm, input logic [31:0] d);
        drive(1'b1, 32'h0, imm, d, 32'h0);
    endtask

    task automatic rd(input logic [15:0] imm, input logic [31:0] prev,
                      input logic [31:0] e, input string r);
        drive(1'b0, 32'h0, imm, 32'h0, prev);
        expect_item(K_RDATA, r, e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] obs;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RDATA: obs = rdata;
                    K_FLUSH: obs = {31'b0, tlb_flush};
                    K_REQ:   obs = {31'b0, redirect_req};
                    K_RPC:   obs = redirect_pc;
                    default: obs = {31'b0, dslot_clr};
                endcase
                checks++;
                if (obs !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, obs, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        idle();
        expect_item(K_FLUSH, "R10", 32'h0);
        expect_item(K_REQ,   "R10", 32'h0);
        expect_item(K_DCLR,  "R10", 32'h0);
        rd(A_SR,     32'hFFFF_FFFF, 32'h1, "R10");
        rd(A_PICEN,  32'hFFFF_FFFF, 32'h0, "R10");
        rd(A_PICPND, 32'hFFFF_FFFF, 32'h0, "R10");
        rd(A_MACLO,  32'hFFFF_FFFF, 32'h0, "R10");
        rd(A_MACHI,  32'hFFFF_FFFF, 32'h0, "R10");

        // R7: no request passes the old value; unknown group too
        idle(); req_rd_prev = 32'h1234_5678;
        expect_item(K_RDATA, "R7", 32'h1234_5678);
        rd(16'h1807, 32'hCAFE_F00D, 32'hCAFE_F00D, "R7");

        // R2: fixed identification, writes ignored
        rd(A_COREID, 32'hAAAA_AAAA, 32'h0, "R2");
        rd(A_NCORES, 32'hAAAA_AAAA, 32'h1, "R2");
        wr(A_COREID, 32'h5);
        wr(A_NCORES, 32'h7);
        rd(A_COREID, 32'hAAAA_AAAA, 32'h0, "R2");
        rd(A_NCORES, 32'hAAAA_AAAA, 32'h1, "R2");

        // R1: base OR immediate; out-of-range addresses ignored
        drive(1'b1, 32'h0000_2800, 16'h0001, 32'h1111_1111, 32'h0);
        drive(1'b0, 32'h0000_2801, 16'h0000, 32'h0, 32'h0);
        expect_item(K_RDATA, "R1", 32'h1111_1111);
        drive(1'b0, 32'h0001_0000, 16'h2801, 32'h0, 32'hBEEF_0001);
        expect_item(K_RDATA, "R1", 32'hBEEF_0001);
        drive(1'b1, 32'h0001_0000, A_EPCR, 32'h9999_9999, 32'h0);
        rd(A_EPCR, 32'h0, 32'h0, "R1");

        // R5: accumulator halves independent
        wr(A_MACHI, 32'h2222_2222);
        wr(A_MACLO, 32'h3333_3333);
        rd(A_MACHI, 32'h0, 32'h2222_2222, "R5");
        rd(A_MACLO, 32'h0, 32'h3333_3333, "R5");

        // R3: enable register accumulates bits
        wr(A_PICEN, 32'h0000_000F);
        wr(A_PICEN, 32'h0000_00F0);
        rd(A_PICEN, 32'h0, 32'h0000_00FF, "R3");
        wr(A_PICEN, 32'h0);
        rd(A_PICEN, 32'h0, 32'h0000_00FF, "R3");

        // R4: pending set by lines, cleared by writes, set wins
        idle(); irq_i = 32'h0000_00FF;
        @(negedge clk); irq_i = 32'h0;
        rd(A_PICPND, 32'h0, 32'h0000_00FF, "R4");
        wr(A_PICPND, 32'h0000_000F);
        rd(A_PICPND, 32'h0, 32'h0000_00F0, "R4");
        wr(A_PICPND, 32'h0000_0030); irq_i = 32'h0000_0010;
        idle(); irq_i = 32'h0;
        rd(A_PICPND, 32'h0, 32'h0000_00D0, "R4");

        // R6: flush only when watched status bits change
        wr(A_SR, 32'h0000_0021);
        idle(); expect_item(K_FLUSH, "R6", 32'h1);
        idle(); expect_item(K_FLUSH, "R6", 32'h0);
        wr(A_SR, 32'h0000_0029);
        idle(); expect_item(K_FLUSH, "R6", 32'h0);
        wr(A_SR, 32'h0000_0028);
        idle(); expect_item(K_FLUSH, "R6", 32'h1);
        rd(A_SR, 32'h0, 32'h0000_0028, "R6");

        // R9: exception storage
        wr(A_EPCR,  32'hA000_0001);
        wr(A_EEAR,  32'hB000_0002);
        wr(A_ESR,   32'hC000_0003);
        wr(A_EVBAR, 32'hD000_0004);
        rd(A_EPCR,  32'h0, 32'hA000_0001, "R9");
        rd(A_EEAR,  32'h0, 32'hB000_0002, "R9");
        rd(A_ESR,   32'h0, 32'hC000_0003, "R9");
        rd(A_EVBAR, 32'h0, 32'hD000_0004, "R9");

        // R8: redirect handshake
        rd(A_NPC, 32'h0, 32'h0000_0100, "R8");
        wr(A_NPC, 32'h0000_0100);
        idle(); expect_item(K_REQ, "R8", 32'h0);
        wr(A_NPC, 32'h0000_0200);
        idle();
        expect_item(K_REQ,  "R8", 32'h1);
        expect_item(K_RPC,  "R8", 32'h0000_0200);
        expect_item(K_DCLR, "R8", 32'h1);
        wr(A_NPC, 32'h0000_0300);
        expect_item(K_REQ,  "R8", 32'h1);
        expect_item(K_DCLR, "R8", 32'h0);
        idle();
        expect_item(K_RPC,  "R8", 32'h0000_0200);
        expect_item(K_REQ,  "R8", 32'h1);
        redirect_ack = 1'b1;
        idle(); redirect_ack = 1'b0;
        expect_item(K_REQ, "R8", 32'h0);
        expect_item(K_DCLR, "R8", 32'h0);

        idle(); idle();
        done = 1;
        summary();
        $finish;
    end

endmodule